// File: doc/BRIEF.md
# Halt-Mode Power Sequencing Controller

This block takes a microcontroller core into its deepest power-down state and brings it back out. The instruction decoder raises a one-cycle strobe when the core executes its halt instruction. The controller then does one of two things. If the watchdog is running and the option bit that forbids halting under a live watchdog is set, it raises a watchdog reset request and the core keeps running. Otherwise it stops the main oscillator, the peripheral clocks and the CPU clock, and forces the interrupt mask bits to the value that enables interrupts.

Halt ends only on a reset request or on an interrupt from the wake-capable set. The controller turns the oscillator back on at once. It holds the CPU and peripheral clocks off for a stabilization window of `STAB_CYCLES` oscillator cycles, 4096 by default, counted by an internal counter. It then releases the clocks and emits a one-cycle resume strobe. A vector-select output tells the core to fetch the reset vector or to service the interrupt that woke it. The wake cause is also held in a pending flag until the core acknowledges it. Peripherals that run from an external or auxiliary clock do not pass through this block, so they keep running.

States: RUN (clocks on), HALT (all three enables off), STAB (oscillator on, CPU and peripheral clocks off, counter running) and RESUME (clocks on, strobe high for one cycle). Transitions: RUN to HALT on a halt strobe without the watchdog veto; RUN to RUN with a watchdog reset pulse on a vetoed strobe; HALT to STAB on a reset request or a wake interrupt; STAB to RESUME when the counter reaches its last value; RESUME to RUN unconditionally.

Top module: `halt_seq_ctrl`

## Requirements
- R1: After reset, osc_en, periph_clk_en and cpu_clk_en are 1, and wdg_rst_req, imask_force, resume_strobe and wake_pending are 0.
- R2: A halt_req sampled in RUN while wdg_en and wdg_halt_opt are both 1 gives wdg_rst_req = 1 for exactly the next cycle, and all clock enables stay at 1. With either of those bits at 0, the strobe enters halt instead.
- R3: Any other halt_req sampled in RUN makes osc_en, periph_clk_en and cpu_clk_en 0 from the next cycle. In that first halted cycle only, imask_force is 1, which means the mask bits are set to 2'b00 (interrupts enabled).
- R4: While halted, halt_req and resume_ack have no effect: all enables stay 0 and imask_force stays 0 after the first cycle.
- R5: If wake_irq is already 1 when halt is entered, the halt lasts exactly one cycle and osc_en returns to 1 in the following cycle.
- R6: A wake sampled in HALT (rst_req or wake_irq) sets osc_en to 1 in the next cycle. cpu_clk_en and periph_clk_en then stay 0 for STAB_CYCLES cycles.
- R7: After the delay, resume_strobe is 1 for exactly one cycle, during which cpu_clk_en and periph_clk_en are 1. vec_is_irq is 1 for a wake by interrupt and 0 for a wake by reset.
- R8: Reset takes priority in vector selection. rst_req and wake_irq sampled together in HALT, or rst_req sampled at any time during stabilization, gives vec_is_irq = 0.
- R9: wake_pending becomes 1 together with resume_strobe. It stays 1 until resume_ack is sampled at 1, and is 0 from the next cycle on.
- R10: rst_req and wake_irq sampled in RUN have no effect on the clock enables or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle strobe from the decoder when the halt instruction executes |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_opt | input | 1 | Option bit: halt under a live watchdog becomes a watchdog reset |
| rst_req | input | 1 | Reset request; a wake source |
| wake_irq | input | 1 | Wake-capable interrupt request |
| resume_ack | input | 1 | Core acknowledges the held wake cause |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Gate for the peripheral clocks |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| imask_force | output | 1 | One-cycle pulse: force interrupt mask bits to 2'b00 |
| resume_strobe | output | 1 | One-cycle resume pulse |
| vec_is_irq | output | 1 | Vector select: 1 service interrupt, 0 fetch reset vector |
| wake_pending | output | 1 | Held wake cause awaiting acknowledge |

## Verification
Two things can land in the same cycle. A reset request and a wake interrupt can be sampled together in the HALT state, and a late reset request can arrive while the interrupt wake is already counting down in stabilization. The bench provokes both on purpose: directed cases raise rst_req and wake_irq on the same edge, or pulse rst_req partway through the delay, and random iterations draw both choices. In every case the expected vector is computed so that reset wins, and vec_is_irq is compared against it at the resume strobe.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } hs_state_e;

    typedef enum logic {
        WAKE_BY_RST = 1'b0,
        WAKE_BY_IRQ = 1'b1
    } wake_src_e;

endpackage

// File: rtl/halt_stab_counter.sv
module halt_stab_counter #(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
    import halt_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_req,
    input  logic      wdg_veto,
    input  logic      rst_req,
    input  logic      wake_irq,
    input  logic      stab_done,
    output hs_state_e state,
    output logic      enter_halt,
    output logic      wake_now,
    output logic      osc_en,
    output logic      periph_clk_en,
    output logic      cpu_clk_en,
    output logic      wdg_rst_req,
    output logic      imask_force,
    output logic      resume_strobe
);
    hs_state_e state_q, state_d;
    logic      wdg_fire;
    logic      wdg_q, mask_q;

    assign enter_halt = (state_q == ST_RUN) && halt_req && !wdg_veto;
    assign wdg_fire   = (state_q == ST_RUN) && halt_req &&  wdg_veto;
    assign wake_now   = (state_q == ST_HALT) && (rst_req || wake_irq);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (enter_halt) state_d = ST_HALT;
            ST_HALT:   if (wake_now)   state_d = ST_STAB;
            ST_STAB:   if (stab_done)  state_d = ST_RESUME;
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdg_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            wdg_q  <= wdg_fire;
            mask_q <= enter_halt;
        end
    end

    always_comb begin
        osc_en        = 1'b1;
        periph_clk_en = 1'b1;
        cpu_clk_en    = 1'b1;
        resume_strobe = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_HALT: begin
                osc_en        = 1'b0;
                periph_clk_en = 1'b0;
                cpu_clk_en    = 1'b0;
            end
            ST_STAB: begin
                periph_clk_en = 1'b0;
                cpu_clk_en    = 1'b0;
            end
            ST_RESUME: resume_strobe = 1'b1;
            default: ;
        endcase
    end

    assign wdg_rst_req = wdg_q;
    assign imask_force = mask_q;
    assign state       = state_q;

endmodule

// File: rtl/halt_wake_cause.sv
module halt_wake_cause
    import halt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake_now,
    input  logic wake_rst,
    input  logic stab_rst,
    input  logic resume_now,
    input  logic resume_ack,
    output logic vec_is_irq,
    output logic wake_pending
);
    wake_src_e src_q;
    logic      pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= WAKE_BY_RST;
        end else if (wake_now) begin
            src_q <= wake_rst ? WAKE_BY_RST : WAKE_BY_IRQ;
        end else if (stab_rst) begin
            src_q <= WAKE_BY_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (resume_now) begin
            pend_q <= 1'b1;
        end else if (resume_ack) begin
            pend_q <= 1'b0;
        end
    end

    assign vec_is_irq   = (src_q == WAKE_BY_IRQ);
    assign wake_pending = pend_q;

endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
    import halt_seq_pkg::*;
#(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic wdg_en,
    input  logic wdg_halt_opt,
    input  logic rst_req,
    input  logic wake_irq,
    input  logic resume_ack,
    output logic osc_en,
    output logic periph_clk_en,
    output logic cpu_clk_en,
    output logic wdg_rst_req,
    output logic imask_force,
    output logic resume_strobe,
    output logic vec_is_irq,
    output logic wake_pending
);
    hs_state_e state;
    logic      enter_halt, wake_now, stab_done;
    logic      in_stab;

    assign in_stab = (state == ST_STAB);

    halt_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_req      (halt_req),
        .wdg_veto      (wdg_en && wdg_halt_opt),
        .rst_req       (rst_req),
        .wake_irq      (wake_irq),
        .stab_done     (stab_done),
        .state         (state),
        .enter_halt    (enter_halt),
        .wake_now      (wake_now),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .cpu_clk_en    (cpu_clk_en),
        .wdg_rst_req   (wdg_rst_req),
        .imask_force   (imask_force),
        .resume_strobe (resume_strobe)
    );

    halt_stab_counter #(.STAB_CYCLES(STAB_CYCLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_halt),
        .run   (in_stab),
        .done  (stab_done)
    );

    halt_wake_cause u_cause (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_now     (wake_now),
        .wake_rst     (rst_req),
        .stab_rst     (in_stab && rst_req),
        .resume_now   (in_stab && stab_done),
        .resume_ack   (resume_ack),
        .vec_is_irq   (vec_is_irq),
        .wake_pending (wake_pending)
    );

endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk #(
    parameter int STAB_CYCLES = 4096
) (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic wdg_en,
    input logic wdg_halt_opt,
    input logic resume_ack,
    input logic osc_en,
    input logic periph_clk_en,
    input logic cpu_clk_en,
    input logic wdg_rst_req,
    input logic imask_force,
    input logic resume_strobe,
    input logic wake_pending
);
    localparam int WIN_W = $clog2(STAB_CYCLES + 2) + 1;

    logic [WIN_W-1:0] dark_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dark_cnt <= '0;
        end else if (!osc_en || cpu_clk_en) begin
            dark_cnt <= '0;
        end else begin
            dark_cnt <= dark_cnt + 1'b1;
        end
    end

    AST_CLOCKS_OFF_WITH_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en)); // R3

    AST_MASK_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        imask_force |-> !osc_en); // R3

    AST_WDG_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |-> (osc_en && cpu_clk_en && $past(halt_req && wdg_en && wdg_halt_opt))); // R2

    AST_STAB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (dark_cnt == WIN_W'(STAB_CYCLES))); // R6

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_strobe |=> !resume_strobe); // R7

    AST_RESUME_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        resume_strobe |-> (cpu_clk_en && periph_clk_en)); // R7

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pending && !resume_ack) |=> wake_pending); // R9

    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pending && resume_ack && !resume_strobe) |=> !wake_pending); // R9

endmodule

bind halt_seq_ctrl halt_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) i_halt_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_req      (halt_req),
    .wdg_en        (wdg_en),
    .wdg_halt_opt  (wdg_halt_opt),
    .resume_ack    (resume_ack),
    .osc_en        (osc_en),
    .periph_clk_en (periph_clk_en),
    .cpu_clk_en    (cpu_clk_en),
    .wdg_rst_req   (wdg_rst_req),
    .imask_force   (imask_force),
    .resume_strobe (resume_strobe),
    .wake_pending  (wake_pending)
);

// File: tb/test_halt_seq_ctrl.sv
`timescale 1ns/1ps
module test_halt_seq_ctrl;
    localparam int STAB = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, wdg_en = 1'b0, wdg_halt_opt = 1'b0;
    logic rst_req = 1'b0, wake_irq = 1'b0, resume_ack = 1'b0;
    logic osc_en, periph_clk_en, cpu_clk_en, wdg_rst_req;
    logic imask_force, resume_strobe, vec_is_irq, wake_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    halt_seq_ctrl #(.STAB_CYCLES(STAB)) i_halt_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdg_en(wdg_en),
        .wdg_halt_opt(wdg_halt_opt), .rst_req(rst_req), .wake_irq(wake_irq),
        .resume_ack(resume_ack), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
        .cpu_clk_en(cpu_clk_en), .wdg_rst_req(wdg_rst_req), .imask_force(imask_force),
        .resume_strobe(resume_strobe), .vec_is_irq(vec_is_irq), .wake_pending(wake_pending)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] clk_vec(logic o, logic p, logic c);
        return {o, p, c};
    endfunction

    function automatic logic expected_vec(bit pending, bit rst_at_wake, bit rst_in_stab);
        if (rst_in_stab) return 1'b0;
        if (pending) return 1'b1;
        return !rst_at_wake;
    endfunction

    task automatic do_halt(bit we, bit opt, bit pending, int hold, bit use_rst,
                           bit use_irq, bit rst_in_stab, int ack_delay);
        logic exp_irq;
        wdg_en = we; wdg_halt_opt = opt;
        halt_req = 1'b1; wake_irq = pending;
        step();
        halt_req = 1'b0;
        if (we && opt) begin
            wake_irq = 1'b0;
            chk("R2 wdg pulse", wdg_rst_req, 1'b1);
            chk("R2 clocks stay on", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b111);
            step();
            chk("R2 wdg pulse single", wdg_rst_req, 1'b0);
            chk("R2 still running", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b111);
            return;
        end
        chk("R3 clocks off", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b000);
        chk("R3 mask force", imask_force, 1'b1);
        if (pending) begin
            step();
            wake_irq = 1'b0;
            chk("R5 immediate wake osc", osc_en, 1'b1);
            chk("R5 cpu still off", cpu_clk_en, 1'b0);
        end else begin
            for (int h = 0; h < hold; h++) begin
                halt_req = 1'($urandom_range(0, 1));
                resume_ack = 1'($urandom_range(0, 1));
                step();
                chk("R4 halted", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b000);
                chk("R4 mask single", imask_force, 1'b0);
            end
            halt_req = 1'b0; resume_ack = 1'b0;
            rst_req = use_rst; wake_irq = use_irq;
            step();
            rst_req = 1'b0; wake_irq = 1'b0;
            chk("R6 osc on at wake", osc_en, 1'b1);
            chk("R6 cpu off at wake", clk_vec(1'b0, periph_clk_en, cpu_clk_en), 3'b000);
        end
        exp_irq = expected_vec(pending, use_rst, rst_in_stab);
        for (int i = 1; i < STAB; i++) begin
            if (rst_in_stab && i == 100) rst_req = 1'b1;
            step();
            rst_req = 1'b0;
        end
        chk("R6 cpu off through delay", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b100);
        step();
        chk("R7 resume strobe", resume_strobe, 1'b1);
        chk("R7 clocks on", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b111);
        chk("R8 R7 vector select", vec_is_irq, exp_irq);
        chk("R9 pending set", wake_pending, 1'b1);
        step();
        chk("R7 strobe single", resume_strobe, 1'b0);
        for (int d = 0; d < ack_delay; d++) begin
            step();
            chk("R9 pending held", wake_pending, 1'b1);
        end
        resume_ack = 1'b1;
        step();
        resume_ack = 1'b0;
        chk("R9 pending cleared", wake_pending, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 clocks on", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b111);
        chk("R1 strobes low", {wdg_rst_req, imask_force, resume_strobe, wake_pending}, 4'b0000);

        rst_req = 1'b1; wake_irq = 1'b1;
        step();
        rst_req = 1'b0; wake_irq = 1'b0;
        step();
        chk("R10 run ignores wake", clk_vec(osc_en, periph_clk_en, cpu_clk_en), 3'b111);
        chk("R10 no strobes", {resume_strobe, imask_force, wake_pending}, 3'b000);

        do_halt(1, 1, 0, 0, 0, 0, 0, 0);   // R2 veto
        do_halt(1, 0, 0, 5, 0, 1, 0, 2);   // R2 opt clear -> halt, irq wake
        do_halt(0, 0, 0, 3, 1, 1, 0, 0);   // R8 rst and irq together
        do_halt(0, 1, 1, 0, 0, 0, 0, 1);   // R5 pending at entry
        do_halt(0, 0, 0, 2, 0, 1, 1, 0);   // R8 rst during stabilize

        for (int n = 0; n < 12; n++) begin
            bit we, opt, pend, ur, ui, rs;
            we = 1'($urandom_range(0, 1));
            opt = 1'($urandom_range(0, 1));
            pend = ($urandom_range(0, 3) == 0);
            ur = 1'($urandom_range(0, 1));
            ui = ur ? 1'($urandom_range(0, 1)) : 1'b1;
            rs = ($urandom_range(0, 3) == 0);
            do_halt(we, opt, pend, int'($urandom_range(1, 12)), ur, ui, rs,
                    int'($urandom_range(0, 3)));
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule